// File: doc/BRIEF.md
# Linked-List Transfer Descriptor Walker

This block walks a chain of transfer descriptors kept in memory and turns each one into a command for a downstream data mover. Software first loads the byte address of the first descriptor into the next-descriptor pointer, then raises the run bit. The block then raises busy and reads the chain one 32-bit word at a time over a request/grant memory port with a variable-latency read-valid return. Each live descriptor is placed in a small command FIFO that both the read side and the write side of the data mover consume.

Each descriptor occupies four consecutive words. Word offset 0 holds the source address, offset 4 the destination address, offset 8 the byte address of the next descriptor, and offset 12 a control word. In the control word, bits 15:0 carry the transfer length and bit 31 is the hardware-ownership flag. The chain ends at the first descriptor whose ownership flag is 0. Such a descriptor is read but never turned into a command. The walker fetches ahead: it starts reading the next descriptor as soon as the current one has been queued, and it pauses only when the FIFO is full.

Top module: `dw_walker`

## Requirements
- R1: After reset, busy, lnk_misalign, rd_req and cmd_valid are all 0.
- R2: When run rises while idle and the pointer has both low bits at 0, busy is 1 from the very next clock edge, and the first read goes to the pointer address.
- R3: A start pointer or a followed next-link with nonzero bits 1:0 sets lnk_misalign. In that case no read is issued at that address, and busy is 0 afterwards.
- R4: The four words of a descriptor are read in the order offset 0, 4, 8, 12 (source, destination, next link, control word).
- R5: Commands leave the FIFO in list order, each carrying the source, the destination and the control word bits 15:0 of its descriptor.
- R6: A descriptor whose control word bit 31 is 0 is read but not queued. The walk then stops, busy clears, and nxt_ptr_q holds that descriptor's address.
- R7: The fetch of the next descriptor starts while earlier commands are still unconsumed in the FIFO.
- R8: With a FIFO of FIFO_DEPTH entries held full, the walker reads exactly one descriptor beyond it and then issues no read. No command is lost or repeated when the FIFO drains.
- R9: A read request holds its address steady until it is granted, and only one read is outstanding at a time.
- R10: When run drops during a walk, the descriptor being read is still completed and queued. The block then goes idle with nxt_ptr_q at that descriptor's next link and issues no further reads.
- R11: Writes to the pointer while busy is 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nxt_ptr_we | input | 1 | Pointer register write strobe |
| nxt_ptr_wdata | input | 32 | Pointer write value (byte address) |
| nxt_ptr_q | output | 32 | Current pointer, updated to each followed link |
| run | input | 1 | Run bit of the control register |
| busy | output | 1 | Walk in progress |
| lnk_misalign | output | 1 | Misaligned start or link seen |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read byte address |
| rd_gnt | input | 1 | Memory accepts the request |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data word |
| cmd_valid | output | 1 | Command FIFO not empty |
| cmd_ready | input | 1 | Data mover takes the head command |
| cmd_src | output | 32 | Command source address |
| cmd_dst | output | 32 | Command destination address |
| cmd_len | output | 16 | Command transfer length |

## Verification
A corrupted word index or state register shows up on rd_addr within one read. The offset sequence breaks, or a request appears while a read is still outstanding. A wrong ownership decision appears once the FIFO drains: either a command too many, or a command missing and the walk stopping early. In both cases busy and nxt_ptr_q also disagree with the terminating address. A full-flag or pointer-wrap error in the FIFO shows up as a repeated or missing command, or as a read count above the single allowed look-ahead descriptor, within FIFO_DEPTH pushes.

// File: rtl/dw_pkg.sv
package dw_pkg;
   localparam int unsigned ADDR_W  = 32;
   localparam int unsigned LEN_W   = 16;
   localparam int unsigned OWN_BIT = 31;

   typedef enum logic [1:0] {
      W_SRC = 2'd0,
      W_DST = 2'd1,
      W_NXT = 2'd2,
      W_CTL = 2'd3
   } dw_word_e;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_REQ  = 2'd1,
      S_WAIT = 2'd2,
      S_PUSH = 2'd3
   } dw_state_e;

   typedef struct packed {
      logic [ADDR_W-1:0] src;
      logic [ADDR_W-1:0] dst;
      logic [LEN_W-1:0]  len;
   } dw_cmd_t;

   localparam int unsigned CMD_W = $bits(dw_cmd_t);
endpackage

// File: rtl/dw_cmd_fifo.sv
module dw_cmd_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             full,
   output logic             empty
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("dw_cmd_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] store [DEPTH];
   logic [PTR_W-1:0] wp, rp;
   logic [CNT_W-1:0] cnt;

   assign full    = (cnt == CNT_W'(DEPTH));
   assign empty   = (cnt == '0);
   assign rd_data = store[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (wr_en) wp <= wp + 1'b1;
         if (rd_en) rp <= rp + 1'b1;
         case ({wr_en, rd_en})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (wr_en && wp == PTR_W'(g)) store[g] <= wr_data;
      end
   end

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (cnt < CNT_W'(DEPTH)));
   p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (cnt != '0));
endmodule

// File: rtl/dw_fetch_fsm.sv
module dw_fetch_fsm
   import dw_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              ptr_we,
   input  logic [ADDR_W-1:0] ptr_wdata,
   output logic [ADDR_W-1:0] ptr_q,
   output logic              busy,
   output logic              misalign,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic              push,
   output dw_cmd_t           push_cmd,
   input  logic              fifo_full
);
   dw_state_e         state;
   logic              run_q;
   logic [1:0]        widx;
   logic [ADDR_W-1:0] ptr, src_r, dst_r, nxt_r;
   logic [LEN_W-1:0]  len_r;
   logic              start;

   assign start    = (state == S_IDLE) && run && !run_q;
   assign mem_req  = (state == S_REQ);
   assign mem_addr = ptr + ADDR_W'({widx, 2'b00});
   assign push     = (state == S_PUSH) && !fifo_full;
   assign push_cmd = '{src: src_r, dst: dst_r, len: len_r};
   assign ptr_q    = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         run_q    <= 1'b0;
         widx     <= '0;
         ptr      <= '0;
         src_r    <= '0;
         dst_r    <= '0;
         nxt_r    <= '0;
         len_r    <= '0;
         busy     <= 1'b0;
         misalign <= 1'b0;
      end else begin
         run_q <= run;
         unique case (state)
            S_IDLE: begin
               if (ptr_we) ptr <= ptr_wdata;
               if (start) begin
                  if (ptr[1:0] != 2'b00) begin
                     misalign <= 1'b1;
                  end else begin
                     misalign <= 1'b0;
                     busy     <= 1'b1;
                     widx     <= W_SRC;
                     state    <= S_REQ;
                  end
               end
            end
            S_REQ: if (mem_gnt) state <= S_WAIT;
            S_WAIT: if (mem_rvalid) begin
               unique case (dw_word_e'(widx))
                  W_SRC: src_r <= mem_rdata;
                  W_DST: dst_r <= mem_rdata;
                  W_NXT: nxt_r <= mem_rdata;
                  W_CTL: len_r <= mem_rdata[LEN_W-1:0];
               endcase
               if (widx != W_CTL) begin
                  widx  <= widx + 1'b1;
                  state <= S_REQ;
               end else if (!mem_rdata[OWN_BIT]) begin
                  busy  <= 1'b0;
                  state <= S_IDLE;
               end else begin
                  state <= S_PUSH;
               end
            end
            S_PUSH: if (!fifo_full) begin
               ptr  <= nxt_r;
               widx <= W_SRC;
               if (!run) begin
                  busy  <= 1'b0;
                  state <= S_IDLE;
               end else if (nxt_r[1:0] != 2'b00) begin
                  misalign <= 1'b1;
                  busy     <= 1'b0;
                  state    <= S_IDLE;
               end else begin
                  state <= S_REQ;
               end
            end
         endcase
      end
   end

   p_busy_next_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ptr[1:0] == 2'b00) |=> (busy && mem_req));
   p_req_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));
   p_no_req_with_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rvalid |-> !mem_req);
   p_push_when_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> busy);
   p_ptr_frozen_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(push)) |-> $stable(ptr));
endmodule

// File: rtl/dw_walker.sv
module dw_walker #(
   parameter int unsigned FIFO_DEPTH = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        nxt_ptr_we,
   input  logic [31:0] nxt_ptr_wdata,
   output logic [31:0] nxt_ptr_q,
   input  logic        run,
   output logic        busy,
   output logic        lnk_misalign,
   output logic        rd_req,
   output logic [31:0] rd_addr,
   input  logic        rd_gnt,
   input  logic        rd_valid,
   input  logic [31:0] rd_data,
   output logic        cmd_valid,
   input  logic        cmd_ready,
   output logic [31:0] cmd_src,
   output logic [31:0] cmd_dst,
   output logic [15:0] cmd_len
);
   import dw_pkg::*;

   if (ADDR_W != 32 || LEN_W != 16) begin : g_bad_fmt
      $error("dw_walker: port widths assume 32-bit addresses and 16-bit lengths");
   end

   logic    push, full, empty, pop;
   dw_cmd_t push_cmd;
   logic [CMD_W-1:0] head_raw;
   dw_cmd_t head;

   assign pop       = cmd_valid && cmd_ready;
   assign cmd_valid = !empty;
   assign head      = dw_cmd_t'(head_raw);
   assign cmd_src   = head.src;
   assign cmd_dst   = head.dst;
   assign cmd_len   = head.len;

   dw_fetch_fsm i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .ptr_we    (nxt_ptr_we),
      .ptr_wdata (nxt_ptr_wdata),
      .ptr_q     (nxt_ptr_q),
      .busy      (busy),
      .misalign  (lnk_misalign),
      .mem_req   (rd_req),
      .mem_addr  (rd_addr),
      .mem_gnt   (rd_gnt),
      .mem_rvalid(rd_valid),
      .mem_rdata (rd_data),
      .push      (push),
      .push_cmd  (push_cmd),
      .fifo_full (full)
   );

   dw_cmd_fifo #(.WIDTH(CMD_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (push),
      .wr_data(push_cmd),
      .rd_en  (pop),
      .rd_data(head_raw),
      .full   (full),
      .empty  (empty)
   );

   p_idle_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> busy);
   p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lnk_misalign) |-> !busy);
endmodule

// File: tb/test_dw_walker.sv
module test_dw_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nxt_ptr_we = 1'b0;
   logic [31:0] nxt_ptr_wdata = '0;
   logic [31:0] nxt_ptr_q;
   logic        run = 1'b0;
   logic        busy, lnk_misalign, rd_req, rd_gnt, cmd_valid;
   logic [31:0] rd_addr;
   logic        rd_valid = 1'b0;
   logic [31:0] rd_data = '0;
   logic        cmd_ready = 1'b0;
   logic [31:0] cmd_src, cmd_dst;
   logic [15:0] cmd_len;

   always #10 clk = ~clk;

   dw_walker #(.FIFO_DEPTH(4)) i_dw_walker (.*);

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // memory model: 256 words, request/grant then latency-delayed valid
   logic [31:0] mem [256];
   logic        gnt_ok = 1'b1;
   int          gnt_pct = 0;
   int          lat_cfg = 1;
   int          lat_cnt = 0;
   logic        pending = 1'b0;
   logic [31:0] pend_addr = '0;
   int          n_rd = 0;
   logic [31:0] rd_log [64];
   assign rd_gnt = rd_req & gnt_ok;

   always @(posedge clk) begin
      rd_valid <= 1'b0;
      gnt_ok   <= (($urandom % 100) >= gnt_pct);
      if (pending) begin
         if (lat_cnt <= 1) begin
            rd_valid <= 1'b1;
            rd_data  <= mem[pend_addr[9:2]];
            pending  <= 1'b0;
         end else lat_cnt <= lat_cnt - 1;
      end else if (rd_req && rd_gnt) begin
         pending   <= 1'b1;
         lat_cnt   <= lat_cfg;
         pend_addr <= rd_addr;
         if (n_rd < 64) rd_log[n_rd] <= rd_addr;
         n_rd <= n_rd + 1;
      end
   end

   // consumer with optional back-pressure
   int          bp_pct = 0;
   logic        hold_off = 1'b0;
   int          got_n = 0;
   logic [31:0] got_src [16];
   logic [31:0] got_dst [16];
   logic [15:0] got_len [16];
   always @(posedge clk) begin
      if (cmd_valid && cmd_ready && got_n < 16) begin
         got_src[got_n] <= cmd_src;
         got_dst[got_n] <= cmd_dst;
         got_len[got_n] <= cmd_len;
      end
      if (cmd_valid && cmd_ready) got_n <= got_n + 1;
      cmd_ready <= !hold_off && (($urandom % 100) >= bp_pct);
   end

   // expected list
   logic [31:0] d_addr [8];
   logic [31:0] e_src [8];
   logic [31:0] e_dst [8];
   logic [15:0] e_len [8];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | i;
   endtask

   // builds n live descriptors plus one terminator, scattered in memory
   task automatic build(input int n, input int base, input int step);
      for (int i = 0; i <= n; i++) d_addr[i] = base + ((i * step) % 8) * 32;
      for (int i = 0; i <= n; i++) begin
         e_src[i] = 32'h1000_0000 + i * 32'h111 + base;
         e_dst[i] = 32'h2000_0000 + i * 32'h222 + step;
         e_len[i] = 16'(16'h40 * (i + 1) + n);
         mem[d_addr[i][9:2]]     = e_src[i];
         mem[d_addr[i][9:2] + 1] = e_dst[i];
         mem[d_addr[i][9:2] + 2] = (i < n) ? d_addr[i+1] : 32'h0000_0300;
         mem[d_addr[i][9:2] + 3] = {(i < n), 15'h7F00 >> i, e_len[i]};
      end
   endtask

   task automatic arm(input logic [31:0] p);
      @(negedge clk);
      run = 1'b0;
      @(negedge clk);
      nxt_ptr_we = 1'b1;
      nxt_ptr_wdata = p;
      @(negedge clk);
      nxt_ptr_we = 1'b0;
      got_n = 0;
      n_rd  = 0;
   endtask

   task automatic go();
      @(negedge clk);
      chk(busy == 1'b0, "R2", "busy before run edge", busy, 0);
      run = 1'b1;
      @(negedge clk);
   endtask

   task automatic wait_idle(input int lim);
      for (int i = 0; i < lim && busy; i++) @(negedge clk);
   endtask

   task automatic drain(input int lim);
      for (int i = 0; i < lim && cmd_valid; i++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic check_cmds(input int n, input string req);
      chk(got_n == n, req, "command count", got_n, n);
      for (int i = 0; i < n && i < got_n; i++) begin
         chk(got_src[i] == e_src[i], req, "cmd src", got_src[i], e_src[i]);
         chk(got_dst[i] == e_dst[i], req, "cmd dst", got_dst[i], e_dst[i]);
         chk(got_len[i] == e_len[i], req, "cmd len", got_len[i], e_len[i]);
      end
   endtask

   // {n_desc, latency, backpressure %, base/step}
   localparam logic [31:0] VEC [5] = '{
      {8'd1, 8'd1, 8'd0,  8'h13},
      {8'd3, 8'd2, 8'd50, 8'h25},
      {8'd6, 8'd3, 8'd75, 8'h13},
      {8'd6, 8'd1, 8'd0,  8'h07},
      {8'd3, 8'd5, 8'd30, 8'h21}
   };

   initial begin
      int start_rd;
      clear_mem();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 0, "R1", "busy in reset", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && rd_req == 0, "R1", "busy/req after reset", {busy, rd_req}, 0);
      chk(cmd_valid == 0 && lnk_misalign == 0, "R1", "valid/err after reset",
          {cmd_valid, lnk_misalign}, 0);

      for (int v = 0; v < 5; v++) begin
         int n, base, step;
         n = VEC[v][31:24];
         lat_cfg = VEC[v][23:16];
         bp_pct  = VEC[v][15:8];
         base = VEC[v][7:4] * 64;
         step = VEC[v][3:0];
         gnt_pct = bp_pct / 2;
         clear_mem();
         build(n, base, step);
         arm(d_addr[0]);
         go();
         chk(busy == 1'b1, "R2", "busy one edge after run", busy, 1);
         wait_idle(5000);
         drain(500);
         check_cmds(n, "R5");
         chk(n_rd == 4 * (n + 1), "R6", "reads incl. terminator", n_rd, 4 * (n + 1));
         chk(nxt_ptr_q == d_addr[n], "R6", "pointer at terminator", nxt_ptr_q, d_addr[n]);
         chk(rd_log[0] == d_addr[0], "R2", "first read address", rd_log[0], d_addr[0]);
         for (int w = 0; w < 4; w++)
            chk(rd_log[4 + w] == d_addr[1] + 4 * w, "R4", "word order",
                rd_log[4 + w], d_addr[1] + 4 * w);
         start_rd = n_rd;
         repeat (20) @(negedge clk);
         chk(n_rd == start_rd && got_n == n, "R6", "nothing after terminator",
             n_rd, start_rd);
      end

      // R3 misaligned start pointer
      gnt_pct = 0; bp_pct = 0; lat_cfg = 1;
      arm(32'h0000_0106);
      go();
      repeat (4) @(negedge clk);
      chk(lnk_misalign == 1, "R3", "start misalign flag", lnk_misalign, 1);
      chk(busy == 0 && n_rd == 0, "R3", "no busy, no read", n_rd, 0);

      // R3 misaligned link after first descriptor
      clear_mem();
      build(2, 0, 3);
      mem[d_addr[0][9:2] + 2] = d_addr[1] | 32'h1;
      arm(d_addr[0]);
      go();
      chk(lnk_misalign == 0, "R3", "flag cleared on good start", lnk_misalign, 0);
      wait_idle(2000);
      drain(200);
      chk(lnk_misalign == 1, "R3", "link misalign flag", lnk_misalign, 1);
      chk(got_n == 1 && n_rd == 4, "R3", "one cmd, no bad read", n_rd, 4);

      // R7/R8/R11 fetch-ahead and full stall
      clear_mem();
      build(6, 256, 5);
      hold_off = 1'b1;
      lat_cfg = 2;
      arm(d_addr[0]);
      go();
      for (int i = 0; i < 200 && !cmd_valid; i++) @(negedge clk);
      start_rd = n_rd;
      for (int i = 0; i < 40 && n_rd == start_rd; i++) @(negedge clk);
      chk(n_rd > start_rd && got_n == 0, "R7", "next fetch before consume", n_rd, start_rd + 1);
      repeat (300) @(negedge clk);
      chk(n_rd == 20, "R8", "one descriptor beyond full", n_rd, 20);
      nxt_ptr_we = 1'b1; nxt_ptr_wdata = 32'h0000_0040;
      @(negedge clk);
      nxt_ptr_we = 1'b0;
      repeat (50) @(negedge clk);
      chk(n_rd == 20 && busy == 1, "R8", "stalled while full", n_rd, 20);
      hold_off = 1'b0;
      wait_idle(2000);
      drain(200);
      check_cmds(6, "R8");
      chk(nxt_ptr_q == d_addr[6], "R11", "pointer write while busy ignored",
          nxt_ptr_q, d_addr[6]);

      // R10 run dropped mid-walk
      clear_mem();
      build(6, 512, 3);
      lat_cfg = 3;
      arm(d_addr[0]);
      go();
      for (int i = 0; i < 2000 && got_n < 2; i++) @(negedge clk);
      run = 1'b0;
      wait_idle(2000);
      drain(200);
      chk(got_n >= 2 && got_n < 6, "R10", "stopped early", got_n, 2);
      check_cmds(got_n, "R10");
      chk(nxt_ptr_q == d_addr[got_n], "R10", "pointer at next link",
          nxt_ptr_q, d_addr[got_n]);
      chk(n_rd == 4 * got_n, "R10", "in-flight finished only", n_rd, 4 * got_n);
      start_rd = n_rd;
      repeat (30) @(negedge clk);
      chk(n_rd == start_rd, "R10", "no reads after idle", n_rd, start_rd);

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      wait (cyc > 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule